// File: doc/BRIEF.md
# Per-Slave Bus Arbiter with Parking

This block decides which of several bus masters owns one slave port of a multi-master interconnect. Each slave port gets its own copy, so contention on one slave never affects another. Every cycle it looks at the master request vector. A strobe from a separate scheduling block says whether ownership may change now. When the strobe is high, a new owner is chosen by round-robin or by fixed priority, depending on the policy input.

When nobody requests at a permitted point, the park mode decides what the grant becomes. It can go idle, stay with the last owner, or move to one configured master. A master parked this way already holds the grant when its request arrives, so it sees no arbitration delay. Any other master is granted on the clock edge after its request is seen, which costs one cycle. Once the slave is busy every cycle, parking gives no gain, because the grant is then always decided by live requests.

The grant is a registered one-hot vector, and the index of the owner comes with it. Address and data steering, the slave protocol and the timing of permitted points all belong to other blocks.

Top module: `slave_port_arbiter`

## Requirements
- R1: While reset is held low, and right after it is released, `gnt_o` is all zero and `gnt_idx_o` is 0.
- R2: `gnt_o` and `gnt_idx_o` change only on a clock edge where `rearb_ok_i` was high in the cycle before that edge. Otherwise they keep their values, whatever the requests are.
- R3: With `pol_fixed_i`=0 (round-robin), the search starts at the master after the last one granted on a request, and wraps from the top index to 0. After reset the first search starts at master 0.
- R4: With `pol_fixed_i`=1 (fixed priority), the requesting master with the largest value in its `prio_i` field wins. Master i's field is bits [i*PW +: PW]. On equal values the lower index wins.
- R5: A request seen in a cycle with `rearb_ok_i` high produces a grant to a requesting master on the next clock edge, which is one cycle of latency.
- R6: With park mode 0 (`park_mode_i`=2'd0), no request and `rearb_ok_i` high, the grant becomes all zero and `gnt_idx_o` becomes 0.
- R7: With park mode 1 (`park_mode_i`=2'd1), no request and `rearb_ok_i` high, the current owner keeps the grant.
- R8: With park mode 2 (`park_mode_i`=2'd2), no request and `rearb_ok_i` high, the grant moves to master `park_idx_i`. A request from that master then finds its grant already high in the same cycle, so it sees zero latency.
- R9: `gnt_o` never has more than one bit set. When it is non-zero, `gnt_idx_o` is the position of that bit.
- R10: Park mode 3 (`park_mode_i`=2'd3) behaves like park mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | N | Request from each master |
| pol_fixed_i | input | 1 | 0: round-robin, 1: fixed priority |
| prio_i | input | N*PW | Priority field of each master, master i at [i*PW +: PW] |
| park_mode_i | input | 2 | Idle behaviour: 0 none, 1 keep last, 2 fixed master, 3 none |
| park_idx_i | input | IW | Master parked on in park mode 2 |
| rearb_ok_i | input | 1 | Ownership may change in this cycle |
| gnt_o | output | N | Registered one-hot grant |
| gnt_idx_o | output | IW | Index of the granted master, 0 when none |

## Verification
Round-robin is driven with all masters requesting, which shows the rotation and the wrap from master 3 back to 0. It is then driven with a sparse subset, which shows that the search skips silent masters and starts just after the last winner. Fixed priority is given distinct values, a tie, and an all-equal case, which separates "largest value wins" from "lower index wins". Idle periods are run under each park mode, and requests are raised while `rearb_ok_i` is low. Together these separate holding, dropping and parking, and they show the zero-cycle latency of the parked master against the one-cycle latency of the others.

// File: rtl/arb_pkg.sv
package arb_pkg;

    typedef enum logic [1:0] {
        PARK_NONE  = 2'd0,
        PARK_LAST  = 2'd1,
        PARK_FIXED = 2'd2,
        PARK_NONE2 = 2'd3
    } park_mode_e;

    typedef enum logic {
        POL_ROUND = 1'b0,
        POL_PRIO  = 1'b1
    } policy_e;

endpackage

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  req_i,
    input  logic [IW-1:0] last_i,
    output logic [IW-1:0] win_o,
    output logic          found_o
);
    int cand;

    always_comb begin
        win_o   = '0;
        found_o = 1'b0;
        cand    = 0;
        for (int off = 1; off <= N; off++) begin
            cand = (int'(last_i) + off) % N;
            if (!found_o && req_i[cand]) begin
                found_o = 1'b1;
                win_o   = IW'(cand);
            end
        end
    end

    // R3: the chosen master must be one that is requesting
    always_comb begin
        if (found_o) begin
            p_rr_win_req_r3: assert (req_i[win_o]);
        end
    end
endmodule

// File: rtl/arb_prio_pick.sv
module arb_prio_pick #(
    parameter int N  = 4,
    parameter int PW = 2,
    parameter int IW = 2
) (
    input  logic [N-1:0]    req_i,
    input  logic [N*PW-1:0] prio_i,
    output logic [IW-1:0]   win_o,
    output logic            found_o
);
    logic [PW-1:0] level [N];
    logic [PW-1:0] best;

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_unpack
            assign level[g] = prio_i[g*PW +: PW];
        end
    endgenerate

    always_comb begin
        win_o   = '0;
        found_o = 1'b0;
        best    = '0;
        for (int i = 0; i < N; i++) begin
            if (req_i[i] && (!found_o || level[i] > best)) begin
                found_o = 1'b1;
                best    = level[i];
                win_o   = IW'(i);
            end
        end
    end

    // R4: winner requests and no requester holds a larger value
    always_comb begin
        if (found_o) begin
            p_prio_win_req_r4: assert (req_i[win_o]);
            for (int i = 0; i < N; i++) begin
                if (req_i[i]) begin
                    p_prio_max_r4: assert (level[i] <= level[win_o]);
                end
            end
        end
    end
endmodule

// File: rtl/slave_port_arbiter.sv
module slave_port_arbiter
    import arb_pkg::*;
#(
    parameter int N  = 4,
    parameter int PW = 2,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    req_i,
    input  logic            pol_fixed_i,
    input  logic [N*PW-1:0] prio_i,
    input  logic [1:0]      park_mode_i,
    input  logic [IW-1:0]   park_idx_i,
    input  logic            rearb_ok_i,
    output logic [N-1:0]    gnt_o,
    output logic [IW-1:0]   gnt_idx_o
);
    typedef struct packed {
        logic [N-1:0]  gnt;
        logic [IW-1:0] idx;
        logic [IW-1:0] last;
    } arb_st_t;

    arb_st_t st_d, st_q;

    logic [IW-1:0] rr_win, pr_win, win;
    logic          rr_found, pr_found, any_req;
    policy_e       pol;

    arb_rr_pick #(.N(N), .IW(IW)) i_rr (
        .req_i   (req_i),
        .last_i  (st_q.last),
        .win_o   (rr_win),
        .found_o (rr_found)
    );

    arb_prio_pick #(.N(N), .PW(PW), .IW(IW)) i_prio (
        .req_i   (req_i),
        .prio_i  (prio_i),
        .win_o   (pr_win),
        .found_o (pr_found)
    );

    assign pol     = policy_e'(pol_fixed_i);
    assign win     = (pol == POL_PRIO) ? pr_win : rr_win;
    assign any_req = (pol == POL_PRIO) ? pr_found : rr_found;

    always_comb begin
        st_d = st_q;
        if (rearb_ok_i) begin
            if (any_req) begin
                st_d.gnt  = N'(1) << win;
                st_d.idx  = win;
                st_d.last = win;
            end else begin
                case (park_mode_e'(park_mode_i))
                    PARK_LAST: begin
                        st_d.gnt = st_q.gnt;
                        st_d.idx = st_q.idx;
                    end
                    PARK_FIXED: begin
                        if (int'(park_idx_i) < N) begin
                            st_d.gnt = N'(1) << park_idx_i;
                            st_d.idx = park_idx_i;
                        end else begin
                            st_d.gnt = '0;
                            st_d.idx = '0;
                        end
                    end
                    default: begin
                        st_d.gnt = '0;
                        st_d.idx = '0;
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.gnt  <= '0;
            st_q.idx  <= '0;
            st_q.last <= IW'(N - 1);
        end else begin
            st_q <= st_d;
        end
    end

    assign gnt_o     = st_q.gnt;
    assign gnt_idx_o = st_q.idx;

    // R2: no permitted point, no change
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !rearb_ok_i |=> ($stable(gnt_o) && $stable(gnt_idx_o)));

    // R5: a request at a permitted point is served at the next edge
    p_serve_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rearb_ok_i && (req_i != '0)) |=> ((gnt_o & $past(req_i)) != '0));

    // R6 / R10: idle without parking drops the grant
    p_idle_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rearb_ok_i && (req_i == '0) && (park_mode_i[0] == park_mode_i[1]))
        |=> (gnt_o == '0 && gnt_idx_o == '0));

    // R7: keep-last parking holds the owner
    p_keep_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rearb_ok_i && (req_i == '0) && (park_mode_i == 2'd1)) |=> $stable(gnt_o));

    // R8: fixed parking lands on the configured master
    p_park_fixed_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rearb_ok_i && (req_i == '0) && (park_mode_i == 2'd2) && (int'(park_idx_i) < N))
        |=> (gnt_idx_o == $past(park_idx_i) && gnt_o[gnt_idx_o]));

    // R9: at most one owner, index agrees with the grant
    p_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_o));
    p_idx_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_o != '0) |-> gnt_o[gnt_idx_o]);
endmodule

// File: tb/test_slave_port_arbiter.sv
`timescale 1ns/1ps
module test_slave_port_arbiter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] req = '0;
    logic       pol = 1'b0;
    logic [7:0] prio = '0;
    logic [1:0] pmode = '0;
    logic [1:0] pidx = '0;
    logic       rearb = 1'b0;
    logic [3:0] gnt;
    logic [1:0] gidx;

    int checks = 0;
    int errs   = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    slave_port_arbiter #(.N(4), .PW(2)) i_slave_port_arbiter (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (req),
        .pol_fixed_i (pol),
        .prio_i      (prio),
        .park_mode_i (pmode),
        .park_idx_i  (pidx),
        .rearb_ok_i  (rearb),
        .gnt_o       (gnt),
        .gnt_idx_o   (gidx)
    );

    task automatic chk(input logic [3:0] eg, input logic [1:0] ei, input string tag);
        checks++;
        if (gnt !== eg || gidx !== ei) begin
            errs++;
            $display("FAIL %s: gnt=%b idx=%0d expected gnt=%b idx=%0d", tag, gnt, gidx, eg, ei);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; req = '0; pol = 1'b0; prio = '0;
        pmode = '0; pidx = '0; rearb = 1'b0;
        step();
        step();
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        chk(4'b0000, 2'd0, "R1 reset state");
        rearb = 1'b1;
        step();
        chk(4'b0000, 2'd0, "R1 idle after reset");
    endtask

    task automatic t_round_robin();
        do_reset();
        rearb = 1'b1; req = 4'b1111;
        step(); chk(4'b0001, 2'd0, "R3 first from master 0");
        step(); chk(4'b0010, 2'd1, "R3 rotate to 1");
        step(); chk(4'b0100, 2'd2, "R3 rotate to 2");
        step(); chk(4'b1000, 2'd3, "R3 rotate to 3");
        step(); chk(4'b0001, 2'd0, "R3 wrap to 0");
        req = 4'b1010;
        step(); chk(4'b0010, 2'd1, "R3 skip to 1");
        step(); chk(4'b1000, 2'd3, "R3 skip to 3");
        step(); chk(4'b0010, 2'd1, "R3 wrap skip to 1");
        checks++;
        if ($countones(gnt) > 1) begin
            errs++;
            $display("FAIL R9: gnt=%b expected at most one bit", gnt);
        end
    endtask

    task automatic t_priority();
        do_reset();
        rearb = 1'b1; pol = 1'b1;
        prio = {2'd1, 2'd3, 2'd3, 2'd2};
        req = 4'b1111;
        step(); chk(4'b0010, 2'd1, "R4 tie goes to lower index");
        step(); chk(4'b0010, 2'd1, "R4 same winner again");
        req = 4'b1001;
        step(); chk(4'b0001, 2'd0, "R4 larger value wins");
        prio = '0; req = 4'b1100;
        step(); chk(4'b0100, 2'd2, "R4 all equal lowest index");
    endtask

    task automatic t_hold();
        do_reset();
        rearb = 1'b1; req = 4'b0001;
        step(); chk(4'b0001, 2'd0, "R2 initial owner");
        rearb = 1'b0; req = 4'b1110;
        step(); chk(4'b0001, 2'd0, "R2 held with other requests");
        step(); chk(4'b0001, 2'd0, "R2 held second cycle");
        req = 4'b0000;
        step(); chk(4'b0001, 2'd0, "R2 held while idle");
        rearb = 1'b1; req = 4'b1110;
        step(); chk(4'b0010, 2'd1, "R2 change once permitted");
    endtask

    task automatic t_latency();
        do_reset();
        rearb = 1'b1; pmode = 2'd2; pidx = 2'd2;
        step(); chk(4'b0100, 2'd2, "R8 parked on master 2");
        req = 4'b0100;
        #0; chk(4'b0100, 2'd2, "R8 zero latency for parked master");
        step(); chk(4'b0100, 2'd2, "R8 parked master keeps grant");
        req = 4'b0001;
        #0; chk(4'b0100, 2'd2, "R5 other master not yet granted");
        step(); chk(4'b0001, 2'd0, "R5 granted one cycle later");
        req = 4'b0000;
        step(); chk(4'b0100, 2'd2, "R8 back to parked master");
    endtask

    task automatic t_park_none();
        do_reset();
        rearb = 1'b1; pmode = 2'd0; req = 4'b0010;
        step(); chk(4'b0010, 2'd1, "R6 owner before idle");
        req = 4'b0000;
        step(); chk(4'b0000, 2'd0, "R6 grant dropped");
        pmode = 2'd3; req = 4'b1000;
        step(); chk(4'b1000, 2'd3, "R10 owner before idle");
        req = 4'b0000;
        step(); chk(4'b0000, 2'd0, "R10 mode 3 drops grant");
    endtask

    task automatic t_park_last();
        do_reset();
        rearb = 1'b1; pmode = 2'd1; req = 4'b0100;
        step(); chk(4'b0100, 2'd2, "R7 owner before idle");
        req = 4'b0000;
        step(); chk(4'b0100, 2'd2, "R7 kept while idle");
        step(); chk(4'b0100, 2'd2, "R7 kept second idle cycle");
        req = 4'b0001;
        step(); chk(4'b0001, 2'd0, "R7 new owner");
        req = 4'b0000;
        step(); chk(4'b0001, 2'd0, "R7 new owner kept");
    endtask

    initial begin
        t_reset();
        t_round_robin();
        t_priority();
        t_hold();
        t_latency();
        t_park_none();
        t_park_last();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1'b1;
            checks++;
            errs++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule